// File: doc/BRIEF.md
# Virtual-Channel Input Pipeline Controller

This block is the control logic for one input virtual channel of a wormhole router that uses credit-based flow control. It accepts flits from the upstream link and stores them in a small FIFO. In the same cycle that a flit is written, it computes a dimension-ordered output port from the destination coordinates the flit carries. Each packet then moves through four stages: buffer write with route computation, output-VC allocation, switch allocation, and switch traversal.

The output VC allocator and the switch allocator are external. The block talks to each of them through a level request and a single-cycle grant. A packet's head flit wins an output VC. Body and tail flits reuse that VC, and it stays reserved until the last flit of the packet leaves.

Downstream buffer space is tracked by one credit counter per output VC. A flit is sent only when the counter for its VC is nonzero. Each flit removed from the FIFO sends one credit back upstream.

Flits are released to traversal through a separate counter of admitted flits. That counter grows by at most one per cycle, and only while the channel is idle or in traversal. As a result, flits that arrive after the head still pass through both the buffer and the traversal stage.

Top module: `vc_input_pipe`

## Requirements
- R1: After reset, `outValid`, `vcReq`, `saReq`, `creditRet` and `vcFree` are low. Each output VC's credit count starts at `CREDITS`.
- R2: The route uses X before Y. Port codes are:
  - 1 (east) when dstX > myX;
  - 2 (west) when dstX < myX;
  - otherwise 3 (north) when dstY > myY;
  - 4 (south) when dstY < myY;
  - 0 (local) when both coordinates match.
  
  The code is presented on `vcReqPort`, `saReqPort` and `outPort`.
- R3: `vcReq` is raised once per packet, and only for the flit at the FIFO front that has type head (00) or single (11). It stays high, with a stable `vcReqPort`, until `vcGnt` is seen.
- R4: Every flit of a packet leaves with the granted VC id on `outVc`. `saReq` is low in the cycle right after the cycle in which `vcGnt` was seen.
- R5: Flits leave in arrival order with type, coordinates and payload unchanged. Type encoding: 00 head, 01 body, 10 tail, 11 single.
- R6: No flit is sent while the credit count of its output VC is zero. While a flit waits for credit, `saReq` is low. Each send decrements the count, and each `dsCreditRet[v]` pulse increments the count for VC v.
- R7: Every flit removed from the FIFO gives exactly one single-cycle `creditRet` pulse, in the same cycle as `outValid`.
- R8: The output VC stays reserved until the tail leaves. `vcFree` pulses with `vcFreeId` equal to the granted VC in the cycle the tail (10) or single (11) flit is on the output, and at no other time. No new `vcReq` is raised while the VC is reserved.
- R9: If `saReq` is not granted, the request stays high and nothing is sent.
- R10: A single-flit packet requests a VC, is sent, and frees the VC in one pass.
- R11: Body and tail flits that arrive after the head has departed are still admitted and sent. The count of admitted flits never exceeds FIFO occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myX | input | COORD_W | Router's own X coordinate |
| myY | input | COORD_W | Router's own Y coordinate |
| inValid | input | 1 | Flit arriving from upstream |
| inType | input | 2 | Arriving flit type |
| inDstX | input | COORD_W | Arriving flit destination X |
| inDstY | input | COORD_W | Arriving flit destination Y |
| inData | input | DATA_W | Arriving flit payload |
| creditRet | output | 1 | Credit pulse to upstream, one per dequeued flit |
| vcReq | output | 1 | Output-VC allocation request |
| vcReqPort | output | 3 | Output port the VC is requested for |
| vcGnt | input | 1 | Output-VC grant |
| vcGntId | input | OVC_W | Granted output VC id |
| saReq | output | 1 | Switch allocation request |
| saReqPort | output | 3 | Output port requested from the switch |
| saGnt | input | 1 | Switch grant |
| outValid | output | 1 | Flit on the crossbar output |
| outType | output | 2 | Outgoing flit type |
| outDstX | output | COORD_W | Outgoing flit destination X |
| outDstY | output | COORD_W | Outgoing flit destination Y |
| outData | output | DATA_W | Outgoing flit payload |
| outPort | output | 3 | Output port of the outgoing flit |
| outVc | output | OVC_W | Output VC of the outgoing flit |
| dsCreditRet | input | NUM_OVC | Credit returns from downstream, one bit per output VC |
| vcFree | output | 1 | Output VC released (tail departing) |
| vcFreeId | output | OVC_W | Id of the released VC |

## Verification
The assertions take four things for granted about the inputs:
- Upstream never writes a full FIFO unless a flit leaves in the same cycle.
- Packets are well formed: a head, then bodies, then a tail, or else a single flit.
- Grants arrive only while the matching request is high.
- Downstream never returns more credits than it was sent flits.

The bench keeps to these rules in four ways:
- It counts its own upstream credits from `creditRet` and holds the next flit until one is free.
- It builds every packet from a length.
- Its allocator models grant only in answer to a visible request.
- Its downstream model returns one credit for each flit it has seen on a VC, and can be paused to force a credit stall.

// File: rtl/vcpipe_pkg.sv
package vcpipe_pkg;

  typedef enum logic [1:0] {
    FT_HEAD   = 2'b00,
    FT_BODY   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flitType_t;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } outPort_t;

  typedef enum logic [2:0] {
    STG_IB,
    STG_VCREQ,
    STG_VCDONE,
    STG_SAREQ,
    STG_ST
  } stage_t;

  // strobes from control to datapath
  typedef struct packed {
    logic deq;
    logic freeVc;
  } pipeStrobe_t;

endpackage

// File: rtl/vcpipe_route.sv
module vcpipe_route import vcpipe_pkg::*; #(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  output logic [2:0]         port
);

  // X is resolved fully before Y is considered
  always_comb begin
    if (dstX > myX)      port = PORT_EAST;
    else if (dstX < myX) port = PORT_WEST;
    else if (dstY > myY) port = PORT_NORTH;
    else if (dstY < myY) port = PORT_SOUTH;
    else                 port = PORT_LOCAL;
  end

endmodule

// File: rtl/vcpipe_datapath.sv
module vcpipe_datapath import vcpipe_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int COORD_W = 3,
  parameter int DEPTH   = 4,
  parameter int NUM_OVC = 4,
  parameter int CREDITS = 4,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int OVC_W  = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CRED_W = $clog2(CREDITS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               inValid,
  input  logic [1:0]         inType,
  input  logic [COORD_W-1:0] inDstX,
  input  logic [COORD_W-1:0] inDstY,
  input  logic [DATA_W-1:0]  inData,
  input  pipeStrobe_t        strb,
  input  logic [OVC_W-1:0]   vcSel,
  input  logic [NUM_OVC-1:0] dsCreditRet,
  output logic [1:0]         headType,
  output logic [2:0]         headRoute,
  output logic [COORD_W-1:0] headDstX,
  output logic [COORD_W-1:0] headDstY,
  output logic [DATA_W-1:0]  headData,
  output logic [OCC_W-1:0]   occupancy,
  output logic               creditOk
);

  logic [1:0]         typeMem  [DEPTH];
  logic [COORD_W-1:0] xMem     [DEPTH];
  logic [COORD_W-1:0] yMem     [DEPTH];
  logic [DATA_W-1:0]  dataMem  [DEPTH];
  logic [2:0]         routeMem [DEPTH];

  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [2:0]         inRoute;
  logic [CRED_W-1:0]  credCnt [NUM_OVC];

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // route computed in the write cycle, stored beside the flit
  vcpipe_route #(.COORD_W(COORD_W)) u_route (
    .myX  (myX),
    .myY  (myY),
    .dstX (inDstX),
    .dstY (inDstY),
    .port (inRoute)
  );

  always_ff @(posedge clk) begin
    if (inValid) begin
      typeMem[wrPtr]  <= inType;
      xMem[wrPtr]     <= inDstX;
      yMem[wrPtr]     <= inDstY;
      dataMem[wrPtr]  <= inData;
      routeMem[wrPtr] <= inRoute;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (inValid)  wrPtr <= bumpPtr(wrPtr);
      if (strb.deq) rdPtr <= bumpPtr(rdPtr);
      occupancy <= occupancy + OCC_W'(inValid) - OCC_W'(strb.deq);
    end
  end

  assign headType  = typeMem[rdPtr];
  assign headRoute = routeMem[rdPtr];
  assign headDstX  = xMem[rdPtr];
  assign headDstY  = yMem[rdPtr];
  assign headData  = dataMem[rdPtr];

  // downstream credit counters, one per output VC
  for (genvar g = 0; g < NUM_OVC; g++) begin : g_cred
    logic take;
    assign take = strb.deq && (vcSel == OVC_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)                          credCnt[g] <= CRED_W'(CREDITS);
      else if (take && !dsCreditRet[g])  credCnt[g] <= credCnt[g] - CRED_W'(1);
      else if (!take && dsCreditRet[g])  credCnt[g] <= credCnt[g] + CRED_W'(1);
    end

    // R6
    credit_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      take |-> (credCnt[g] != '0));
    // R6
    credit_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      credCnt[g] <= CRED_W'(CREDITS));
  end

  assign creditOk = (credCnt[vcSel] != '0);

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (occupancy < OCC_W'(DEPTH)) || strb.deq);
  // R7
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.deq |-> (occupancy != '0));
  // R8
  free_with_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeVc |-> strb.deq);

endmodule

// File: rtl/vcpipe_ctrl.sv
module vcpipe_ctrl import vcpipe_pkg::*; #(
  parameter int DEPTH   = 4,
  parameter int NUM_OVC = 4,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int OVC_W  = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       headType,
  input  logic [2:0]       headRoute,
  input  logic [OCC_W-1:0] occupancy,
  input  logic             creditOk,
  output logic             vcReq,
  input  logic             vcGnt,
  input  logic [OVC_W-1:0] vcGntId,
  output logic             saReq,
  input  logic             saGnt,
  output logic [2:0]       routeReg,
  output logic [OVC_W-1:0] ovcReg,
  output pipeStrobe_t      strb
);

  stage_t           stage, stageNext;
  logic             moving, movingNext;
  logic [OCC_W-1:0] admitted, admitNext;
  logic             admitInc;
  logic             isLast;

  assign isLast = (headType == FT_TAIL) || (headType == FT_SINGLE);

  always_comb begin
    admitInc    = ((stage == STG_IB) || (stage == STG_ST)) && (admitted < occupancy);
    strb.deq    = (stage == STG_ST) && moving;
    strb.freeVc = strb.deq && isLast;
    admitNext   = admitted + OCC_W'(admitInc) - OCC_W'(strb.deq);
    vcReq       = (stage == STG_VCREQ);
    saReq       = (stage == STG_SAREQ) && (admitted != '0) && creditOk;
  end

  always_comb begin
    stageNext  = stage;
    movingNext = moving;
    unique case (stage)
      STG_IB:     if (admitted != '0) stageNext = STG_VCREQ;
      STG_VCREQ:  if (vcGnt) stageNext = STG_VCDONE;
      STG_VCDONE: stageNext = STG_SAREQ;
      STG_SAREQ: begin
        if (saReq && saGnt) begin
          stageNext  = STG_ST;
          movingNext = 1'b1;
        end
      end
      STG_ST: begin
        if (moving) begin
          if (isLast) begin
            stageNext  = STG_IB;
            movingNext = 1'b0;
          end else if (admitNext != '0) begin
            stageNext  = STG_SAREQ;
            movingNext = 1'b0;
          end else begin
            movingNext = 1'b0;
          end
        end else if (admitted != '0) begin
          stageNext = STG_SAREQ;
        end
      end
      default: stageNext = STG_IB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage    <= STG_IB;
      moving   <= 1'b0;
      admitted <= '0;
      routeReg <= '0;
      ovcReg   <= '0;
    end else begin
      stage    <= stageNext;
      moving   <= movingNext;
      admitted <= admitNext;
      if (vcReq && vcGnt) begin
        routeReg <= headRoute;
        ovcReg   <= vcGntId;
      end
    end
  end

  // R3
  vc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    vcReq && !vcGnt |=> vcReq && $stable(headRoute));
  // R4
  sa_after_vc_chk: assert property (@(posedge clk) disable iff (!rstN)
    vcReq && vcGnt |=> !saReq);
  // R9
  sa_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    saReq && !saGnt |=> saReq && !strb.deq);
  // R11
  admit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    admitted <= occupancy);

endmodule

// File: rtl/vc_input_pipe.sv
module vc_input_pipe import vcpipe_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int COORD_W = 3,
  parameter int DEPTH   = 4,
  parameter int NUM_OVC = 4,
  parameter int CREDITS = 4,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int OVC_W  = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               inValid,
  input  logic [1:0]         inType,
  input  logic [COORD_W-1:0] inDstX,
  input  logic [COORD_W-1:0] inDstY,
  input  logic [DATA_W-1:0]  inData,
  output logic               creditRet,
  output logic               vcReq,
  output logic [2:0]         vcReqPort,
  input  logic               vcGnt,
  input  logic [OVC_W-1:0]   vcGntId,
  output logic               saReq,
  output logic [2:0]         saReqPort,
  input  logic               saGnt,
  output logic               outValid,
  output logic [1:0]         outType,
  output logic [COORD_W-1:0] outDstX,
  output logic [COORD_W-1:0] outDstY,
  output logic [DATA_W-1:0]  outData,
  output logic [2:0]         outPort,
  output logic [OVC_W-1:0]   outVc,
  input  logic [NUM_OVC-1:0] dsCreditRet,
  output logic               vcFree,
  output logic [OVC_W-1:0]   vcFreeId
);

  pipeStrobe_t      strb;
  logic [1:0]       headType;
  logic [2:0]       headRoute;
  logic [OCC_W-1:0] occupancy;
  logic             creditOk;
  logic [2:0]       routeReg;
  logic [OVC_W-1:0] ovcReg;

  vcpipe_datapath #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .DEPTH(DEPTH),
    .NUM_OVC(NUM_OVC), .CREDITS(CREDITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .myX         (myX),
    .myY         (myY),
    .inValid     (inValid),
    .inType      (inType),
    .inDstX      (inDstX),
    .inDstY      (inDstY),
    .inData      (inData),
    .strb        (strb),
    .vcSel       (ovcReg),
    .dsCreditRet (dsCreditRet),
    .headType    (headType),
    .headRoute   (headRoute),
    .headDstX    (outDstX),
    .headDstY    (outDstY),
    .headData    (outData),
    .occupancy   (occupancy),
    .creditOk    (creditOk)
  );

  vcpipe_ctrl #(.DEPTH(DEPTH), .NUM_OVC(NUM_OVC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .headType  (headType),
    .headRoute (headRoute),
    .occupancy (occupancy),
    .creditOk  (creditOk),
    .vcReq     (vcReq),
    .vcGnt     (vcGnt),
    .vcGntId   (vcGntId),
    .saReq     (saReq),
    .saGnt     (saGnt),
    .routeReg  (routeReg),
    .ovcReg    (ovcReg),
    .strb      (strb)
  );

  assign vcReqPort = headRoute;
  assign saReqPort = routeReg;
  assign outPort   = routeReg;
  assign outVc     = ovcReg;
  assign outType   = headType;
  assign outValid  = strb.deq;
  assign creditRet = strb.deq;
  assign vcFree    = strb.freeVc;
  assign vcFreeId  = ovcReg;

endmodule

// File: tb/tb_vc_input_pipe.sv
`timescale 1ns/1ps
module tb_vc_input_pipe;

  localparam int DEPTH   = 4;
  localparam int CREDITS = 4;
  localparam int NUM_OVC = 4;
  localparam int MY_X    = 3;
  localparam int MY_Y    = 3;

  typedef struct packed {
    logic [1:0]  t;
    logic [2:0]  x;
    logic [2:0]  y;
    logic [15:0] d;
    logic [2:0]  p;
    logic [1:0]  v;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  myX, myY;
  logic        inValid;
  logic [1:0]  inType;
  logic [2:0]  inDstX, inDstY;
  logic [15:0] inData;
  logic        creditRet, vcReq, vcGnt, saReq, saGnt, outValid, vcFree;
  logic [2:0]  vcReqPort, saReqPort, outPort, outDstX, outDstY;
  logic [1:0]  vcGntId, outType, outVc, vcFreeId;
  logic [15:0] outData;
  logic [3:0]  dsCreditRet;

  always #2.5 clk = ~clk;

  vc_input_pipe dut (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .inValid(inValid), .inType(inType), .inDstX(inDstX), .inDstY(inDstY), .inData(inData),
    .creditRet(creditRet), .vcReq(vcReq), .vcReqPort(vcReqPort), .vcGnt(vcGnt), .vcGntId(vcGntId),
    .saReq(saReq), .saReqPort(saReqPort), .saGnt(saGnt),
    .outValid(outValid), .outType(outType), .outDstX(outDstX), .outDstY(outDstY),
    .outData(outData), .outPort(outPort), .outVc(outVc),
    .dsCreditRet(dsCreditRet), .vcFree(vcFree), .vcFreeId(vcFreeId)
  );

  int   checks = 0, fails = 0;
  exp_t expQ[$];
  int   grantQ[$];
  int   sentCnt = 0, retCnt = 0, crRetCnt = 0, grantCnt = 0, outCount = 0;
  int   pktCnt = 0, flitCnt = 0, viol4 = 0, viol8 = 0;
  int   pendRet[NUM_OVC];
  bit   held = 0, prevGnt = 0, vcGntEn = 1, saEn = 1, autoRet = 1;
  int   seq = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] expRoute(input int dx, input int dy);
    if (dx > MY_X) return 3'd1;
    if (dx < MY_X) return 3'd2;
    if (dy > MY_Y) return 3'd3;
    if (dy < MY_Y) return 3'd4;
    return 3'd0;
  endfunction

  // driver: one flit per call, paced by upstream credits
  task automatic sendFlit(input logic [1:0] t, input int dx, input int dy, input int vc);
    exp_t e;
    while ((sentCnt - retCnt) >= DEPTH) @(negedge clk);
    inValid = 1'b1;
    inType  = t;
    inDstX  = 3'(dx);
    inDstY  = 3'(dy);
    inData  = 16'(16'hA000 + seq);
    e = '{t: t, x: 3'(dx), y: 3'(dy), d: 16'(16'hA000 + seq), p: expRoute(dx, dy), v: 2'(vc)};
    seq++;
    sentCnt++;
    flitCnt++;
    expQ.push_back(e);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPacket(input int len, input int dx, input int dy, input int vc, input int gap);
    pktCnt++;
    grantQ.push_back(vc);
    for (int i = 0; i < len; i++) begin
      logic [1:0] t;
      if (len == 1)          t = 2'b11;
      else if (i == 0)       t = 2'b00;
      else if (i == len - 1) t = 2'b10;
      else                   t = 2'b01;
      sendFlit(t, dx, dy, vc);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // monitor, allocator models and downstream credit model
  always @(negedge clk) begin : mon
    exp_t e;
    if (!rstN) begin
      vcGnt       = 1'b0;
      saGnt       = 1'b0;
      dsCreditRet = '0;
    end else begin
      if (vcFree && !outValid) viol8++;
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", {outType, outData}, 0);
        end else begin
          e = expQ.pop_front();
          // R2 R4 R5: port, VC and contents per flit
          check({outType, outDstX, outDstY, outData, outPort, outVc} == e, "R5 R2 R4",
                {outType, outDstX, outDstY, outData, outPort, outVc}, e);
          if (e.t[1]) begin
            check(vcFree && (vcFreeId == e.v), (e.t == 2'b11) ? "R10" : "R8",
                  {vcFree, vcFreeId}, {1'b1, e.v});
            held = 1'b0;
          end else begin
            check(!vcFree, "R8", vcFree, 0);
          end
        end
        outCount++;
        pendRet[outVc]++;
      end
      if (creditRet) begin
        retCnt++;
        crRetCnt++;
      end
      if (prevGnt && saReq) viol4++;
      prevGnt = 1'b0;
      if (vcReq && held) viol8++;
      if (vcReq && vcGntEn && grantQ.size() > 0) begin
        vcGnt   = 1'b1;
        vcGntId = 2'(grantQ.pop_front());
        grantCnt++;
        held    = 1'b1;
        prevGnt = 1'b1;
      end else begin
        vcGnt = 1'b0;
      end
      saGnt = saReq && saEn;
      for (int v = 0; v < NUM_OVC; v++) begin
        if (autoRet && pendRet[v] > 0) begin
          dsCreditRet[v] = 1'b1;
          pendRet[v]--;
        end else begin
          dsCreditRet[v] = 1'b0;
        end
      end
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin : main
    int base;
    for (int v = 0; v < NUM_OVC; v++) pendRet[v] = 0;
    rstN = 1'b0; myX = 3'(MY_X); myY = 3'(MY_Y);
    inValid = 1'b0; inType = 2'b00; inDstX = '0; inDstY = '0; inData = '0;
    vcGnt = 1'b0; vcGntId = '0; saGnt = 1'b0; dsCreditRet = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!outValid,  "R1", outValid, 0);
    check(!vcReq,     "R1", vcReq, 0);
    check(!saReq,     "R1", saReq, 0);
    check(!creditRet, "R1", creditRet, 0);
    check(!vcFree,    "R1", vcFree, 0);

    // R2 every route direction, R10 single-flit packets
    sendPacket(3, 5, 1, 0, 0);
    sendPacket(2, 1, 5, 1, 0);
    sendPacket(1, 3, 6, 2, 0);
    sendPacket(4, 3, 0, 3, 0);
    sendPacket(1, 3, 3, 0, 0);
    drain();

    // R5 back-to-back packets with gaps
    sendPacket(2, 6, 3, 1, 2);
    sendPacket(1, 0, 0, 2, 1);
    sendPacket(3, 2, 7, 3, 0);
    drain();

    // R6 credit stall on VC 2 (R1 initial credits = CREDITS)
    autoRet = 0;
    base = outCount;
    sendPacket(6, 4, 4, 2, 0);
    repeat (30) @(negedge clk);
    check(outCount - base == CREDITS, "R6 R1", outCount - base, CREDITS);
    check(!saReq, "R6", saReq, 0);
    autoRet = 1;
    drain();
    check(outCount - base == 6, "R6", outCount - base, 6);

    // R9 switch grant withheld
    saEn = 0;
    base = outCount;
    sendPacket(2, 0, 3, 1, 0);
    repeat (20) @(negedge clk);
    check(saReq, "R9", saReq, 1);
    check(outCount == base, "R9", outCount - base, 0);
    saEn = 1;
    drain();

    // R11 body and tail trickle in after head departure
    base = outCount;
    pktCnt++;
    grantQ.push_back(3);
    sendFlit(2'b00, 7, 2, 3);
    repeat (15) @(negedge clk);
    check(outCount - base == 1, "R11", outCount - base, 1);
    sendFlit(2'b01, 7, 2, 3);
    repeat (15) @(negedge clk);
    check(outCount - base == 2, "R11", outCount - base, 2);
    sendFlit(2'b10, 7, 2, 3);
    drain();
    check(outCount - base == 3, "R11", outCount - base, 3);

    // end-of-run totals
    check(expQ.size() == 0,     "R5", expQ.size(), 0);
    check(grantCnt == pktCnt,   "R3", grantCnt, pktCnt);
    check(crRetCnt == flitCnt,  "R7", crRetCnt, flitCnt);
    check(viol4 == 0,           "R4", viol4, 0);
    check(viol8 == 0,           "R8", viol8, 0);
    finishRun();
  end

endmodule